// File: doc/BRIEF.md
# Serial Password Lock with LED Chaser

This block is a self-contained lock. It receives a password of fixed length over two bare pins: a shift clock and a data line. Every rising edge of the shift clock moves one data bit into a receive register, least significant bit first. The register is compared at all times against a key that is fixed in the design and cannot be loaded at run time.

While the lock is shut, the LED bank stays dark. After the last received bits match the key, the lock opens and stays open until reset. A single lit LED then runs along the bank, one step every 2^STEP_LOG2 system clocks, and wraps from the last LED to the first.

The password length is a parameter. The base build uses 16 bits, and a 64-bit build behaves the same way in every other respect. Both shift pins are asynchronous to the system clock, so each passes through a two-flop synchroniser before use.

Top module: `serial_lock`

## Requirements
- R1: While reset is asserted, and on release of reset, every LED is off and the lock is shut.
- R2: Bits enter LSB first, so the first bit of a word ends at bit 0. The lock opens when the most recent PW_LEN received bits equal PASSWORD, whatever bits arrived before them.
- R3: If the received bits never equal PASSWORD, all LEDs remain off. This includes a word that differs from the key in a single bit.
- R4: A bit is taken only on a rising edge of the shift clock. Changes on the data line while the shift clock stays high, and falling edges of the shift clock, add no bits.
- R5: The LEDs light exactly four system-clock rising edges after the shift clock rises for the bit that completes the match, and not before.
- R6: While open, exactly one LED is lit. The show starts on LED 0 and moves up one position every 2^STEP_LOG2 system clocks. After LED N_LEDS-1 it returns to LED 0.
- R7: Once open, the lock stays open. Further bits, including non-matching ones, do not stop the show.
- R8: Asserting reset during the show turns all LEDs off at once and shuts the lock.
- R9: A 64-bit build (PW_LEN = 64) opens only on its full 64-bit key, delivered the same way.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| arst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| shift_clk_i | input | 1 | Serial shift clock pin; asynchronous to clk |
| shift_dat_i | input | 1 | Serial data pin; must be stable when shift_clk_i rises |
| led_o | output | N_LEDS | LED bank; one-hot while open, zero while shut |

## Verification
A rise on the shift clock passes through two synchroniser flops. The receive register captures the bit on the third system edge, and the open state registers on the fourth. The bench therefore drives pins just after a falling clock edge and samples the LEDs at falling edges. It expects darkness after three and light after four. Counted from the edge that opens the lock, the chaser position is due at floor(j / 2^STEP_LOG2) mod N_LEDS after j further edges, and the bench compares against that formula on every cycle. Reset clears the LEDs asynchronously, so that check samples one time step after the pin falls, with no clock edge needed.

// File: rtl/serial_lock_pkg.sv
package serial_lock_pkg;
  typedef enum logic {
    LK_SHUT = 1'b0,
    LK_OPEN = 1'b1
  } lock_state_e;
endpackage

// File: rtl/lock_reset_sync.sv
module lock_reset_sync (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);
  logic [1:0] chain_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain_q <= 2'b00;
    else         chain_q <= {chain_q[0], 1'b1};
  end

  assign rst_n_o = chain_q[1];
endmodule

// File: rtl/lock_pin_sync.sv
module lock_pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sclk_i,
  input  logic sdat_i,
  output logic bit_stb_o,
  output logic bit_val_o
);
  // each stage holds {clock pin, data pin} so both stay aligned
  logic [1:0] stage_q [STAGES];
  logic       sclk_prev_q;

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage_q[s] <= 2'b00;
      else if (s == 0) stage_q[s] <= {sclk_i, sdat_i};
      else             stage_q[s] <= stage_q[(s == 0) ? 0 : s - 1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sclk_prev_q <= 1'b0;
    else        sclk_prev_q <= stage_q[STAGES-1][1];
  end

  assign bit_stb_o = stage_q[STAGES-1][1] & ~sclk_prev_q;
  assign bit_val_o = stage_q[STAGES-1][0];
endmodule

// File: rtl/lock_shift_match.sv
module lock_shift_match #(
  parameter int              PW_LEN   = 16,
  parameter logic [PW_LEN-1:0] PASSWORD = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_stb_i,
  input  logic              bit_val_i,
  output logic [PW_LEN-1:0] word_o,
  output logic              match_o
);
  logic [PW_LEN-1:0] word_q, word_d;

  // LSB first: new bits enter at the top and move down
  always_comb begin
    word_d = word_q;
    if (bit_stb_i) word_d = {bit_val_i, word_q[PW_LEN-1:1]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) word_q <= '0;
    else        word_q <= word_d;
  end

  assign word_o  = word_q;
  assign match_o = (word_q == PASSWORD);
endmodule

// File: rtl/lock_chaser.sv
module lock_chaser #(
  parameter int N_LEDS    = 8,
  parameter int STEP_LOG2 = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run_i,
  output logic [N_LEDS-1:0] led_o
);
  localparam int POS_W = (N_LEDS > 1) ? $clog2(N_LEDS) : 1;
  localparam logic [POS_W-1:0] LAST_POS = POS_W'(N_LEDS - 1);

  logic [STEP_LOG2-1:0] div_q, div_d;
  logic [POS_W-1:0]     pos_q, pos_d;
  logic                 step;

  assign step = run_i && (div_q == {STEP_LOG2{1'b1}});

  always_comb begin
    div_d = div_q;
    pos_d = pos_q;
    if (run_i) div_d = div_q + 1'b1;
    if (step)  pos_d = (pos_q == LAST_POS) ? '0 : pos_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q <= '0;
      pos_q <= '0;
    end else begin
      div_q <= div_d;
      pos_q <= pos_d;
    end
  end

  for (genvar i = 0; i < N_LEDS; i++) begin : g_led
    assign led_o[i] = run_i && (pos_q == POS_W'(i));
  end
endmodule

// File: rtl/serial_lock.sv
module serial_lock
  import serial_lock_pkg::*;
#(
  parameter int                PW_LEN    = 16,
  parameter logic [PW_LEN-1:0] PASSWORD  = PW_LEN'(64'h9E37_79B9_7F4A_7C15),
  parameter int                N_LEDS    = 8,
  parameter int                STEP_LOG2 = 4
) (
  input  logic              clk,
  input  logic              arst_n,
  input  logic              shift_clk_i,
  input  logic              shift_dat_i,
  output logic [N_LEDS-1:0] led_o
);
  logic              rst_n;
  logic              bit_stb;
  logic              bit_val;
  logic [PW_LEN-1:0] shift_word;
  logic              match;
  lock_state_e       state_q, state_d;
  logic              unlocked;

  lock_reset_sync u_rst (
    .clk     (clk),
    .arst_n  (arst_n),
    .rst_n_o (rst_n)
  );

  lock_pin_sync #(.STAGES(2)) u_pins (
    .clk       (clk),
    .rst_n     (rst_n),
    .sclk_i    (shift_clk_i),
    .sdat_i    (shift_dat_i),
    .bit_stb_o (bit_stb),
    .bit_val_o (bit_val)
  );

  lock_shift_match #(.PW_LEN(PW_LEN), .PASSWORD(PASSWORD)) u_match (
    .clk       (clk),
    .rst_n     (rst_n),
    .bit_stb_i (bit_stb),
    .bit_val_i (bit_val),
    .word_o    (shift_word),
    .match_o   (match)
  );

  always_comb begin
    state_d = state_q;
    if (match) state_d = LK_OPEN;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= LK_SHUT;
    else        state_q <= state_d;
  end

  assign unlocked = (state_q == LK_OPEN);

  lock_chaser #(.N_LEDS(N_LEDS), .STEP_LOG2(STEP_LOG2)) u_show (
    .clk   (clk),
    .rst_n (rst_n),
    .run_i (unlocked),
    .led_o (led_o)
  );
endmodule

// File: rtl/serial_lock_checker.sv
module serial_lock_checker #(
  parameter int PW_LEN = 16,
  parameter int N_LEDS = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bit_stb,
  input logic [PW_LEN-1:0] word,
  input logic              match,
  input logic              unlocked,
  input logic [N_LEDS-1:0] led
);
  // R3: shut lock means a dark LED bank
  p_dark_when_shut_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !unlocked |-> (led == '0));

  // R7: open state is sticky
  p_stays_open_r7: assert property (@(posedge clk) disable iff (!rst_n)
    unlocked |=> unlocked);

  // R2: a match opens the lock on the next edge
  p_match_opens_r2: assert property (@(posedge clk) disable iff (!rst_n)
    match |=> unlocked);

  // R6: exactly one LED while open
  p_onehot_show_r6: assert property (@(posedge clk) disable iff (!rst_n)
    unlocked |-> $onehot(led));

  // R6: any change of the lit LED is one step upward, with wrap
  p_step_up_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(unlocked) && unlocked && !$stable(led)) |->
      (led == {$past(led[N_LEDS-2:0]), $past(led[N_LEDS-1])}));

  // R4: the receive register moves only on a detected rising edge
  p_shift_on_edge_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_stb |=> $stable(word));
endmodule

bind serial_lock serial_lock_checker #(.PW_LEN(PW_LEN), .N_LEDS(N_LEDS)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .bit_stb  (bit_stb),
  .word     (shift_word),
  .match    (match),
  .unlocked (unlocked),
  .led      (led_o)
);

// File: tb/serial_lock_bench.sv
`timescale 1ns/1ps
module serial_lock_bench;
  localparam logic [15:0] KEY16 = 16'hC3A5;
  localparam logic [63:0] KEY64 = 64'h0123_4567_89AB_CDEF;
  localparam int          K     = 4;
  localparam int          STEP  = 1 << K;

  logic       clk = 1'b0;
  logic       arst_n = 1'b0;
  logic       sclk = 1'b0, sdat = 1'b0;
  logic       sclk_w = 1'b0, sdat_w = 1'b0;
  logic [7:0] led, led_w;
  int         n_checks = 0;
  int         n_fail = 0;

  always #4 clk = ~clk;

  serial_lock #(.PW_LEN(16), .PASSWORD(KEY16), .N_LEDS(8), .STEP_LOG2(K)) u_serial_lock (
    .clk(clk), .arst_n(arst_n), .shift_clk_i(sclk), .shift_dat_i(sdat), .led_o(led));

  serial_lock #(.PW_LEN(64), .PASSWORD(KEY64), .N_LEDS(8), .STEP_LOG2(K)) u_serial_lock_wide (
    .clk(clk), .arst_n(arst_n), .shift_clk_i(sclk_w), .shift_dat_i(sdat_w), .led_o(led_w));

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    arst_n = 1'b0; sclk = 1'b0; sclk_w = 1'b0; sdat = 1'b0; sdat_w = 1'b0;
    repeat (3) @(negedge clk);
    arst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  // one bit: 4 clocks high, 4 low; optional data toggling while high
  task automatic send_bit(input bit wide, input bit v, input bit wiggle);
    if (wide) begin sdat_w = v; sclk_w = 1'b1; end
    else      begin sdat = v;   sclk = 1'b1;   end
    repeat (4) @(negedge clk);
    if (wiggle) for (int i = 0; i < 4; i++) begin
      sdat = ~sdat;
      @(negedge clk);
    end
    if (wide) sclk_w = 1'b0; else sclk = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic send_word(input bit wide, input logic [63:0] w, input int n, input bit wiggle);
    for (int i = 0; i < n; i++) send_bit(wide, w[i], wiggle);
  endtask

  task automatic t_reset();
    @(negedge clk); arst_n = 1'b0; #1;
    check("R1 in reset", led, 8'h00);
    repeat (2) @(negedge clk); arst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 after release", led, 8'h00);
  endtask

  task automatic t_latency();
    do_reset();
    send_word(1'b0, {48'h0, KEY16}, 15, 1'b0);
    sdat = KEY16[15]; sclk = 1'b1;
    repeat (3) @(negedge clk);
    check("R5 dark at 3 edges", led, 8'h00);
    @(negedge clk);
    check("R5 lit at 4 edges", led, 8'h01);
    sclk = 1'b0;
  endtask

  task automatic t_chaser();
    int bad = 0;
    logic [7:0] exp;
    do_reset();
    send_word(1'b0, {48'h0, KEY16}, 15, 1'b0);
    sdat = KEY16[15]; sclk = 1'b1;
    repeat (4) @(negedge clk);
    for (int j = 0; j < 8 * STEP + 2 * STEP; j++) begin
      exp = 8'h01 << ((j / STEP) % 8);
      if (led !== exp) begin
        if (bad == 0) check("R6 chaser position", led, exp);
        bad++;
      end
      if (j == 7 * STEP) check("R6 reaches last LED", led, 8'h80);
      if (j == 8 * STEP) check("R6 wraps to LED 0", led, 8'h01);
      @(negedge clk);
    end
    if (bad == 0) check("R6 chaser sweep", led, led);
    sclk = 1'b0;
  endtask

  task automatic t_prefix();
    do_reset();
    send_word(1'b0, 64'h0000_0000_0000_005B, 7, 1'b0);
    check("R2 dark during prefix", led, 8'h00);
    send_word(1'b0, {48'h0, KEY16}, 16, 1'b0);
    check("R2 open after prefix and key", led, 8'h01);
  endtask

  task automatic t_wrong();
    do_reset();
    send_word(1'b0, {48'h0, {<<{KEY16}}}, 16, 1'b0);
    check("R3 reversed key stays dark", led, 8'h00);
    do_reset();
    send_word(1'b0, {48'h0, KEY16 ^ 16'h0100}, 16, 1'b0);
    check("R3 one bit off stays dark", led, 8'h00);
  endtask

  task automatic t_glitch();
    do_reset();
    send_word(1'b0, {48'h0, KEY16}, 16, 1'b1);
    check("R4 data toggles while high ignored", led, 8'h01);
  endtask

  task automatic t_sticky();
    do_reset();
    send_word(1'b0, {48'h0, KEY16}, 16, 1'b0);
    send_word(1'b0, 64'h0000_0000_000F_0F0F, 20, 1'b0);
    n_checks++;
    if (!$onehot(led)) begin
      n_fail++;
      $display("FAIL R7: actual=%b expected=one-hot", led);
    end
  endtask

  task automatic t_reset_mid();
    do_reset();
    send_word(1'b0, {48'h0, KEY16}, 16, 1'b0);
    check("R8 lit before reset", led, 8'h01);
    arst_n = 1'b0; #1;
    check("R8 dark in reset", led, 8'h00);
    repeat (2) @(negedge clk); arst_n = 1'b1;
    repeat (40) @(negedge clk);
    check("R8 stays shut after reset", led, 8'h00);
  endtask

  task automatic t_wide();
    do_reset();
    send_word(1'b1, {48'h0, KEY64[15:0]}, 16, 1'b0);
    check("R9 partial key dark", led_w, 8'h00);
    do_reset();
    send_word(1'b1, KEY64, 64, 1'b0);
    check("R9 full 64-bit key opens", led_w, 8'h01);
    check("R9 narrow lock untouched", led, 8'h00);
  endtask

  initial begin
    #1_600_000;
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", n_fail, n_checks);
    $finish;
  end

  initial begin
    t_reset();
    t_latency();
    t_chaser();
    t_prefix();
    t_wrong();
    t_glitch();
    t_sticky();
    t_reset_mid();
    t_wide();
    $display("Result: errors=%0d of %0d checks", n_fail, n_checks);
    $finish;
  end
endmodule